// File: doc/BRIEF.md
# Video Controller Control-Port Decoder

This block sits behind the control port of a video controller. The host writes 16-bit words to the port. Each word is decoded in one of two ways. A single word can set one controller register. Otherwise the word is one half of a two-word setup that loads a 16-bit memory address and a 6-bit access code. The address, the access code and a DMA request pulse go to a separate data-port and memory engine. A host read of the port returns a 16-bit status word, assembled from status inputs that other parts of the controller drive.

The two-word setup spreads its fields across both words:

- First word: access-code bits 1:0 sit in word bits 15:14, and address bits 13:0 sit in word bits 13:0.
- Second word: access-code bits 5:2 sit in word bits 7:4, and address bits 15:14 sit in word bits 1:0.

Typical access codes, written from bit 5 down to bit 0, are:

| Target | Write code | Read code |
|--------|------------|-----------|
| VRAM   | 000001     | 000000    |
| CRAM   | 000011     | 001000    |
| VSRAM  | 000101     | 000100    |

Code bits 5:4 select DMA: `11` is VRAM copy, and `10` is either memory-to-VRAM or VRAM fill.

A "second word pending" flag separates the two halves of the setup. While the flag is set, the next control write is always taken as the second half.

Top module: `vcp_control_port`

## Requirements
- R1: After a synchronous active-low reset, these are all zero: the pending flag, the address, the access code, the register strobe, the register index, the register value, the DMA request and the DMA mode.
- R2: A control write is a register command when the pending flag is clear and word bits 15:14 are `10`. In the next cycle `reg_we` is high for exactly one cycle, with `reg_idx` = word bits 12:8 and `reg_val` = word bits 7:0. Word bit 13 has no effect on the index.
- R3: A register command changes neither the address, the access code nor the pending flag.
- R4: A control write is a first address word when the pending flag is clear and word bits 15:14 are not `10`. It loads address bits 13:0 from word bits 13:0 and code bits 1:0 from word bits 15:14, and it sets the pending flag. Address bits 15:14 and code bits 5:2 keep their values.
- R5: A control write while the pending flag is set is a second word. It loads address bits 15:14 from word bits 1:0 and code bits 5:2 from word bits 7:4, and it clears the pending flag. Word bits 15:8, 3 and 2 have no effect.
- R6: While the pending flag is set, a word whose bits 15:14 are `10` is still taken as a second word and raises no `reg_we`.
- R7: A status read (`stat_rd`) or a data-port access (`data_acc`) without a control write clears the pending flag. The latched address and code stay unchanged, so a following word with top bits `10` is a register command.
- R8: A second word with word bit 7 set raises `dma_req` for exactly one cycle in the next cycle. A second word with bit 7 clear raises no request. `dma_mode` always shows code bits 5:4.
- R9: `stat_rdata` is combinational, with zeros in bits 15:10. The remaining bits are, from bit 9 down to bit 0: FIFO empty, FIFO full, vertical interrupt taken, sprite overflow, sprite collision, odd frame, vertical blank, horizontal blank, DMA busy and PAL timing.
- R10: When a control write happens in the same cycle as a status read or data access, the control write decides the next state of the pending flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe, one cycle per word |
| ctl_wdata | input | 16 | Control-port write word |
| stat_rd | input | 1 | Control-port read (status) strobe |
| data_acc | input | 1 | Data-port access strobe, read or write |
| st_fifo_empty | input | 1 | Write FIFO is empty |
| st_fifo_full | input | 1 | Write FIFO is full |
| st_vint | input | 1 | Vertical interrupt has occurred |
| st_spr_ovf | input | 1 | Sprite overflow |
| st_spr_coll | input | 1 | Sprite collision |
| st_odd | input | 1 | Odd frame in interlace |
| st_vblank | input | 1 | In vertical blank |
| st_hblank | input | 1 | In horizontal blank |
| st_dma_busy | input | 1 | DMA engine busy |
| st_pal | input | 1 | PAL timing selected |
| stat_rdata | output | 16 | Assembled status word |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_idx | output | 5 | Register index |
| reg_val | output | 8 | Register value |
| mem_addr | output | 16 | Latched memory address |
| acc_code | output | 6 | Latched access code |
| dma_req | output | 1 | One-cycle DMA request pulse |
| dma_mode | output | 2 | DMA mode, equal to code bits 5:4 |
| word2_pend | output | 1 | Second address word pending |

## Verification
The assertions take for granted that every strobe is a clean one-cycle-per-event level sampled at the clock edge. They also assume that the control word is valid whenever `ctl_wr` is high. Nothing is assumed about how writes, reads and data accesses interleave, so the stimulus mixes all three freely, including writes that coincide with reads or accesses. The random word generator leans toward words with top bits `10` and words with bit 7 set. That makes both the register-pattern-while-pending case and DMA requests common.

// File: rtl/vcp_pkg.sv
// Shared types for the control-port decoder.
// Assumes a fixed 16-bit control word layout; the widths are package constants.
package vcp_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 16;
    localparam int CODE_W = 6;
    localparam int IDX_W  = 5;
    localparam int VAL_W  = 8;
    localparam int LO_A_W = 14;              // address bits carried by word 1
    localparam int LO_C_W = 2;               // code bits carried by word 1
    localparam int HI_A_W = ADDR_W - LO_A_W; // address bits carried by word 2
    localparam int HI_C_W = CODE_W - LO_C_W; // code bits carried by word 2
    localparam int STAT_W = 10;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_REG   = 2'd1,
        CMD_ADDR1 = 2'd2,
        CMD_ADDR2 = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e           kind;
        logic [IDX_W-1:0]    idx;
        logic [VAL_W-1:0]    val;
        logic [LO_A_W-1:0]   a_lo;
        logic [LO_C_W-1:0]   c_lo;
        logic [HI_A_W-1:0]   a_hi;
        logic [HI_C_W-1:0]   c_hi;
        logic                dma;
    } cmd_t;
endpackage

// File: rtl/vcp_cmd_decode.sv
// Classifies one control write and splits it into its fields.
// Assumes the pending flag reflects state before this write; purely combinational.
module vcp_cmd_decode
    import vcp_pkg::*;
(
    input  logic              wr,
    input  logic [WORD_W-1:0] word,
    input  logic              pending,
    output cmd_t              cmd
);
    logic unused_word_bits;

    // Spare bits of the word that no field carries.
    assign unused_word_bits = ^{word[13], word[3:2]};

    // Pick the command kind and slice every field from the word.
    always_comb begin
        cmd.idx  = word[8 +: IDX_W];
        cmd.val  = word[VAL_W-1:0];
        cmd.a_lo = word[LO_A_W-1:0];
        cmd.c_lo = word[WORD_W-1 -: LO_C_W];
        cmd.a_hi = word[HI_A_W-1:0];
        cmd.c_hi = word[4 +: HI_C_W];
        cmd.dma  = word[7];
        if (!wr)
            cmd.kind = CMD_NONE;
        else if (pending)
            cmd.kind = CMD_ADDR2;
        else if (word[15:14] == 2'b10)
            cmd.kind = CMD_REG;
        else
            cmd.kind = CMD_ADDR1;
    end
endmodule

// File: rtl/vcp_addr_latch.sv
// Holds the pending flag, address, access code, register strobe and DMA pulse.
// Assumes the cmd input comes from vcp_cmd_decode in the same cycle.
module vcp_addr_latch
    import vcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              cmd,
    input  logic              clr_pend,
    output logic              pending,
    output logic [ADDR_W-1:0] addr,
    output logic [CODE_W-1:0] code,
    output logic              reg_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [VAL_W-1:0]  reg_val,
    output logic              dma_req
);
    // Pending flag: set by word 1, cleared by word 2 or a port access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (cmd.kind == CMD_ADDR1)
            pending <= 1'b1;
        else if (cmd.kind == CMD_ADDR2)
            pending <= 1'b0;
        else if (cmd.kind == CMD_NONE && clr_pend)
            pending <= 1'b0;
    end

    // Address and code: each half is loaded by its own word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            code <= '0;
        end else if (cmd.kind == CMD_ADDR1) begin
            addr[LO_A_W-1:0] <= cmd.a_lo;
            code[LO_C_W-1:0] <= cmd.c_lo;
        end else if (cmd.kind == CMD_ADDR2) begin
            addr[ADDR_W-1:LO_A_W] <= cmd.a_hi;
            code[CODE_W-1:LO_C_W] <= cmd.c_hi;
        end
    end

    // Register-set strobe with index and value held between commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we  <= 1'b0;
            reg_idx <= '0;
            reg_val <= '0;
        end else begin
            reg_we <= (cmd.kind == CMD_REG);
            if (cmd.kind == CMD_REG) begin
                reg_idx <= cmd.idx;
                reg_val <= cmd.val;
            end
        end
    end

    // DMA request pulse on a second word with code bit 5 set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dma_req <= 1'b0;
        else
            dma_req <= (cmd.kind == CMD_ADDR2) && cmd.dma;
    end

    assert_word1_sets_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.kind == CMD_ADDR1) |=> pending);

    assert_reg_keeps_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.kind == CMD_REG) |=> ($stable(addr) && $stable(code) && $stable(pending)));

    assert_access_clears_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.kind == CMD_NONE && clr_pend) |=> (!pending && $stable(addr) && $stable(code)));

    assert_no_reg_while_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> !reg_we);

    assert_dma_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);
endmodule

// File: rtl/vcp_status_pack.sv
// Packs the ten status inputs into the 16-bit status word.
// Assumes the inputs are already synchronous to the host read; combinational.
module vcp_status_pack
    import vcp_pkg::*;
(
    input  logic [STAT_W-1:0] flags,
    output logic [WORD_W-1:0] word
);
    // Zero-extend the flag vector into the upper bits.
    always_comb begin
        word = '0;
        word[STAT_W-1:0] = flags;
    end
endmodule

// File: rtl/vcp_control_port.sv
// Control-port decoder: register commands, two-word address setup, status read.
// Assumes one strobe cycle per host access; outputs other than status are registered.
module vcp_control_port
    import vcp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic [15:0] ctl_wdata,
    input  logic        stat_rd,
    input  logic        data_acc,
    input  logic        st_fifo_empty,
    input  logic        st_fifo_full,
    input  logic        st_vint,
    input  logic        st_spr_ovf,
    input  logic        st_spr_coll,
    input  logic        st_odd,
    input  logic        st_vblank,
    input  logic        st_hblank,
    input  logic        st_dma_busy,
    input  logic        st_pal,
    output logic [15:0] stat_rdata,
    output logic        reg_we,
    output logic [4:0]  reg_idx,
    output logic [7:0]  reg_val,
    output logic [15:0] mem_addr,
    output logic [5:0]  acc_code,
    output logic        dma_req,
    output logic [1:0]  dma_mode,
    output logic        word2_pend
);
    cmd_t cmd;
    logic [STAT_W-1:0] flags;

    vcp_cmd_decode u_dec (
        .wr      (ctl_wr),
        .word    (ctl_wdata),
        .pending (word2_pend),
        .cmd     (cmd)
    );

    vcp_addr_latch u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .clr_pend (stat_rd | data_acc),
        .pending  (word2_pend),
        .addr     (mem_addr),
        .code     (acc_code),
        .reg_we   (reg_we),
        .reg_idx  (reg_idx),
        .reg_val  (reg_val),
        .dma_req  (dma_req)
    );

    assign flags = {st_fifo_empty, st_fifo_full, st_vint, st_spr_ovf, st_spr_coll,
                    st_odd, st_vblank, st_hblank, st_dma_busy, st_pal};

    vcp_status_pack u_st (
        .flags (flags),
        .word  (stat_rdata)
    );

    assign dma_mode = acc_code[CODE_W-1 -: 2];

    assert_dma_from_word2_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> ($past(ctl_wr) && $past(word2_pend) && $past(ctl_wdata[7])));

    assert_reg_from_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(ctl_wr) && !$past(word2_pend) && ($past(ctl_wdata[15:14]) == 2'b10)));

    assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !word2_pend && ctl_wdata[15:14] != 2'b10) |=> word2_pend);
endmodule

// File: tb/test_vcp_control_port.sv
module test_vcp_control_port;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        stat_rd = 1'b0;
    logic        data_acc = 1'b0;
    logic [9:0]  st = '0;
    logic [15:0] stat_rdata;
    logic        reg_we;
    logic [4:0]  reg_idx;
    logic [7:0]  reg_val;
    logic [15:0] mem_addr;
    logic [5:0]  acc_code;
    logic        dma_req;
    logic [1:0]  dma_mode;
    logic        word2_pend;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // model state
    bit         m_pend;
    logic [15:0] m_addr;
    logic [5:0]  m_code;
    bit         m_we;
    logic [4:0]  m_idx;
    logic [7:0]  m_val;
    bit         m_dma;

    always #(CLK_PERIOD/2) clk = ~clk;

    vcp_control_port i_vcp_control_port (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .stat_rd(stat_rd), .data_acc(data_acc),
        .st_fifo_empty(st[9]), .st_fifo_full(st[8]), .st_vint(st[7]),
        .st_spr_ovf(st[6]), .st_spr_coll(st[5]), .st_odd(st[4]),
        .st_vblank(st[3]), .st_hblank(st[2]), .st_dma_busy(st[1]), .st_pal(st[0]),
        .stat_rdata(stat_rdata), .reg_we(reg_we), .reg_idx(reg_idx), .reg_val(reg_val),
        .mem_addr(mem_addr), .acc_code(acc_code), .dma_req(dma_req),
        .dma_mode(dma_mode), .word2_pend(word2_pend)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model step for one cycle of strobes (R2..R8, R10).
    task automatic model_step(input bit wr, input logic [15:0] w, input bit clr);
        m_we  = 0;
        m_dma = 0;
        if (wr) begin
            if (m_pend) begin
                m_addr[15:14] = w[1:0];
                m_code[5:2]   = w[7:4];
                m_dma         = w[7];
                m_pend        = 0;
            end else if (w[15:14] == 2'b10) begin
                m_we  = 1;
                m_idx = w[12:8];
                m_val = w[7:0];
            end else begin
                m_addr[13:0] = w[13:0];
                m_code[1:0]  = w[15:14];
                m_pend       = 1;
            end
        end else if (clr) begin
            m_pend = 0;
        end
    endtask

    task automatic compare(input string req);
        check({req, " pend"}, {31'b0, word2_pend}, {31'b0, m_pend});
        check({req, " addr"}, {16'b0, mem_addr}, {16'b0, m_addr});
        check({req, " code"}, {26'b0, acc_code}, {26'b0, m_code});
        check({req, " reg_we"}, {31'b0, reg_we}, {31'b0, m_we});
        if (m_we)
            check({req, " reg idx/val"}, {19'b0, reg_idx, reg_val}, {19'b0, m_idx, m_val});
        check({req, " dma_req"}, {31'b0, dma_req}, {31'b0, m_dma});
        check({req, " dma_mode"}, {30'b0, dma_mode}, {30'b0, m_code[5:4]});
    endtask

    // Drive one cycle of strobes at the falling edge, then sample one edge later.
    task automatic step(input bit wr, input logic [15:0] w, input bit rd, input bit acc,
                        input string req);
        ctl_wr = wr; ctl_wdata = w; stat_rd = rd; data_acc = acc;
        @(negedge clk);
        ctl_wr = 0; stat_rd = 0; data_acc = 0;
        model_step(wr, w, rd | acc);
        compare(req);
    endtask

    function automatic logic [15:0] exp_status(input logic [9:0] f);
        return {6'b0, f};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 32'h1D5C;
        void'($urandom(seed));
        m_pend = 0; m_addr = '0; m_code = '0; m_we = 0; m_idx = '0; m_val = '0; m_dma = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R1 reset");
        check("R1 reset reg idx/val", {19'b0, reg_idx, reg_val}, 32'b0);

        // R2/R3: register command, bit 13 ignored
        step(1, 16'h8A34, 0, 0, "R2 reg cmd");
        step(0, 16'h0, 0, 0, "R2 strobe one cycle");
        step(1, 16'hAA55, 0, 0, "R2 bit13 ignored");
        check("R2 idx with bit13", {27'b0, reg_idx}, 32'h0A);
        // R4: first word (VRAM write code low bits 01)
        step(1, 16'h4123, 0, 0, "R4 first word");
        // R5/R8: second word with bit 7 -> DMA
        step(1, 16'hFF8E, 0, 0, "R5 R8 second word dma");
        check("R8 dma_mode", {30'b0, dma_mode}, 32'h2);
        step(0, 16'h0, 0, 0, "R8 dma pulse ends");
        // R6: register pattern while pending
        step(1, 16'h0000, 0, 0, "R4 first word read code");
        step(1, 16'h8011, 0, 0, "R6 reg pattern as word2");
        // R7: status read clears pending, then register command works
        step(1, 16'h7FFF, 0, 0, "R4 first word again");
        step(0, 16'h0, 1, 0, "R7 status read clears");
        step(1, 16'h9F01, 0, 0, "R7 reg after clear");
        step(1, 16'h0ABC, 0, 0, "R4 first word");
        step(0, 16'h0, 0, 1, "R7 data access clears");
        // R10: write coincides with read
        step(1, 16'h4321, 1, 1, "R10 write wins set");
        step(1, 16'h8030, 1, 0, "R10 write wins word2");

        // R9: status word
        for (int k = 0; k < 40; k++) begin
            st = 10'($urandom);
            if (k == 0) st = 10'h3FF;
            if (k == 1) st = 10'h000;
            #1;
            check("R9 status word", {16'b0, stat_rdata}, {16'b0, exp_status(st)});
            @(negedge clk);
        end

        // Random mix
        for (int n = 0; n < 2000; n++) begin
            int op;
            logic [15:0] w;
            op = $urandom_range(0, 9);
            w = 16'($urandom);
            if ($urandom_range(0, 2) == 0) w[15:14] = 2'b10;
            if ($urandom_range(0, 2) == 0) w[7] = 1'b1;
            if (op < 6)       step(1, w, op == 5, op == 4, "R2 R4 R5 R6 R8 R10 random");
            else if (op == 6) step(0, w, 1, 0, "R7 random read");
            else if (op == 7) step(0, w, 0, 1, "R7 random access");
            else              step(0, w, 0, 0, "R3 random idle");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule